// File: doc/BRIEF.md
# Barrel Shifter with Rotate

This block shifts or rotates a 32-bit word in one pass of combinational logic. It is built for the execute stage of a processor datapath. A single select input picks the operand: either a register value or an immediate word. A second select input picks the shift amount: either a 6-bit immediate field or the low 6 bits of a register. A 2-bit type code chooses the operation. The outputs are the shifted word and a shifter carry-out that feeds the status flags.

The core is a cascade of five multiplexer stages that move the word by 1, 2, 4, 8 and 16 positions. Each stage is enabled by one bit of the amount. Left shifts reuse the same right-moving stages by reversing the bit order of the word before the cascade and again after it. A final correction stage handles amounts of zero and amounts of 32 or more, where the cascade alone would give the wrong answer. There is no state and no clock: the outputs follow the inputs within the same cycle.

Top module: `barrel_rotate_shifter`

## Requirements
- R1: With `data_sel` = 0 the shifted operand is `reg_data`; with `data_sel` = 1 it is `imm_data`.
- R2: With `amt_sel` = 0 the amount is `amt_imm`; with `amt_sel` = 1 it is `amt_reg`.
- R3: `shift_type` encodes 00 = logical left, 01 = logical right, 10 = arithmetic right (vacated bits copy bit 31), 11 = rotate right. For amounts 1 to 31 the result is the operand moved by that many positions.
- R4: An amount of 0 passes the operand through unchanged for every type, and `carry_out` equals `carry_in`.
- R5: For logical left, logical right and arithmetic right with amounts 1 to 31, `carry_out` is the last bit shifted out: operand bit (32 - n) for left and operand bit (n - 1) for right.
- R6: For a logical shift of exactly 32, the result is 0. `carry_out` is operand bit 0 for left and operand bit 31 for right.
- R7: For a logical shift of 33 to 63, the result is 0 and `carry_out` is 0.
- R8: For an arithmetic right shift of 32 to 63, every result bit equals operand bit 31, and so does `carry_out`.
- R9: Rotate right uses the amount modulo 32. For any nonzero amount, including 32, `carry_out` equals result bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_data | input | 32 | Operand taken from a register |
| imm_data | input | 32 | Operand taken from immediate data |
| data_sel | input | 1 | Operand select: 0 register, 1 immediate |
| amt_imm | input | 6 | Shift amount from the instruction immediate field |
| amt_reg | input | 6 | Shift amount from the low bits of a register |
| amt_sel | input | 1 | Amount select: 0 immediate field, 1 register |
| shift_type | input | 2 | Operation code (see R3) |
| carry_in | input | 1 | Current carry flag, returned when the amount is 0 |
| result | output | 32 | Shifted or rotated word |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench targets the edges of the amount range. At 0, a design that returned a stale carry would drop the incoming flag. At exactly 32, a design that treated it like 33 would lose the shifted-out bit. For arithmetic right shifts of 32 and above, a design that zero-filled would turn negative operands into 0. For rotates of 32 or more, a design without the modulo would clear the word instead of wrapping it. Every type is also swept across all 64 amounts on two operands and compared with a bit-level model, so a wrong stage distance, a swapped type code or a missed reversal on left shifts shows up as a result mismatch.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    typedef enum logic [1:0] {
        SHT_LSL = 2'b00,
        SHT_LSR = 2'b01,
        SHT_ASR = 2'b10,
        SHT_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/bsh_operand_sel.sv
module bsh_operand_sel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] reg_data,
    input  logic [DATA_W-1:0] imm_data,
    input  logic              data_sel,
    input  logic [AMT_W-1:0]  amt_imm,
    input  logic [AMT_W-1:0]  amt_reg,
    input  logic              amt_sel,
    output logic [DATA_W-1:0] op_data,
    output logic [AMT_W-1:0]  op_amt
);

    always_comb begin
        op_data = data_sel ? imm_data : reg_data;
        op_amt  = amt_sel  ? amt_reg  : amt_imm;
    end

endmodule

// File: rtl/bsh_stage.sv
module bsh_stage #(
    parameter int DATA_W = 32,
    parameter int DIST   = 1
) (
    input  logic [DATA_W-1:0] in_val,
    input  logic              in_c,
    input  logic              en,
    input  logic              rotate,
    input  logic              fill,
    output logic [DATA_W-1:0] out_val,
    output logic              out_c
);

    logic [DIST-1:0] upper;

    always_comb begin
        upper = rotate ? in_val[DIST-1:0] : {DIST{fill}};
        if (en) begin
            out_val = {upper, in_val[DATA_W-1:DIST]};
            out_c   = in_val[DIST-1];
        end else begin
            out_val = in_val;
            out_c   = in_c;
        end
    end

endmodule

// File: rtl/bsh_range_fix.sv
module bsh_range_fix
    import barrel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  shift_kind_e       kind,
    input  logic [DATA_W-1:0] op_data,
    input  logic [AMT_W-1:0]  op_amt,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] core_val,
    input  logic              core_c,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    logic beyond;
    logic exact;
    logic zero_amt;

    always_comb begin
        beyond   = (op_amt >= FULL_AMT);
        exact    = (op_amt == FULL_AMT);
        zero_amt = (op_amt == '0);
        result    = core_val;
        carry_out = core_c;
        unique case (kind)
            SHT_ROR: begin
                result    = core_val;
                carry_out = zero_amt ? carry_in : core_val[DATA_W-1];
            end
            SHT_ASR: begin
                if (beyond) begin
                    result    = {DATA_W{op_data[DATA_W-1]}};
                    carry_out = op_data[DATA_W-1];
                end
            end
            SHT_LSL: begin
                if (beyond) begin
                    result    = '0;
                    carry_out = exact & op_data[0];
                end
            end
            SHT_LSR: begin
                if (beyond) begin
                    result    = '0;
                    carry_out = exact & op_data[DATA_W-1];
                end
            end
            default: begin
                result    = core_val;
                carry_out = core_c;
            end
        endcase
    end

endmodule

// File: rtl/barrel_rotate_shifter.sv
module barrel_rotate_shifter
    import barrel_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input  logic [DATA_W-1:0] reg_data,
    input  logic [DATA_W-1:0] imm_data,
    input  logic              data_sel,
    input  logic [AMT_W-1:0]  amt_imm,
    input  logic [AMT_W-1:0]  amt_reg,
    input  logic              amt_sel,
    input  logic [1:0]        shift_type,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam int STAGES = $clog2(DATA_W);

    shift_kind_e       kind;
    logic [DATA_W-1:0] sel_data;
    logic [AMT_W-1:0]  sel_amt;
    logic [DATA_W-1:0] core_in;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] core_val;
    logic              is_left;
    logic              is_rot;
    logic              fill_bit;

    logic [DATA_W-1:0] chain_val [STAGES+1];
    logic              chain_c   [STAGES+1];

    assign kind = shift_kind_e'(shift_type);

    bsh_operand_sel #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_sel (
        .reg_data (reg_data),
        .imm_data (imm_data),
        .data_sel (data_sel),
        .amt_imm  (amt_imm),
        .amt_reg  (amt_reg),
        .amt_sel  (amt_sel),
        .op_data  (sel_data),
        .op_amt   (sel_amt)
    );

    // Left shifts run through the right-moving cascade on a mirrored word.
    always_comb begin
        is_left  = (kind == SHT_LSL);
        is_rot   = (kind == SHT_ROR);
        fill_bit = (kind == SHT_ASR) & sel_data[DATA_W-1];
        for (int i = 0; i < DATA_W; i++) begin
            core_in[i] = is_left ? sel_data[DATA_W-1-i] : sel_data[i];
        end
    end

    assign chain_val[0] = core_in;
    assign chain_c[0]   = carry_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        bsh_stage #(
            .DATA_W (DATA_W),
            .DIST   (1 << s)
        ) u_stage (
            .in_val  (chain_val[s]),
            .in_c    (chain_c[s]),
            .en      (sel_amt[s]),
            .rotate  (is_rot),
            .fill    (fill_bit),
            .out_val (chain_val[s+1]),
            .out_c   (chain_c[s+1])
        );
    end

    assign core_out = chain_val[STAGES];

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            core_val[i] = is_left ? core_out[DATA_W-1-i] : core_out[i];
        end
    end

    bsh_range_fix #(
        .DATA_W (DATA_W),
        .AMT_W  (AMT_W)
    ) u_fix (
        .kind      (kind),
        .op_data   (sel_data),
        .op_amt    (sel_amt),
        .carry_in  (carry_in),
        .core_val  (core_val),
        .core_c    (chain_c[STAGES]),
        .result    (result),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/barrel_rotate_shifter_chk.sv
module barrel_rotate_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 6
) (
    input logic [DATA_W-1:0] sel_data,
    input logic [AMT_W-1:0]  sel_amt,
    input logic [1:0]        shift_type,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              carry_out
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    always_comb begin
        // R4
        zero_pass_chk: assert (sel_amt != '0 || (result == sel_data && carry_out == carry_in))
            else $error("zero amount altered operand or carry");
        // R7
        logical_beyond_chk: assert (shift_type[1] || sel_amt <= FULL_AMT || (result == '0 && !carry_out))
            else $error("logical shift beyond width not cleared");
        // R8
        asr_saturate_chk: assert (shift_type != 2'b10 || sel_amt < FULL_AMT
                                  || (result == {DATA_W{sel_data[DATA_W-1]}} && carry_out == sel_data[DATA_W-1]))
            else $error("arithmetic shift beyond width not saturated");
        // R9
        ror_carry_chk: assert (shift_type != 2'b11 || sel_amt == '0 || carry_out == result[DATA_W-1])
            else $error("rotate carry not equal to result msb");
        // R9
        ror_ones_chk: assert (shift_type != 2'b11 || $countones(result) == $countones(sel_data))
            else $error("rotate changed the number of set bits");
    end

endmodule

bind barrel_rotate_shifter barrel_rotate_shifter_chk #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
) u_chk (
    .sel_data   (sel_data),
    .sel_amt    (sel_amt),
    .shift_type (shift_type),
    .carry_in   (carry_in),
    .result     (result),
    .carry_out  (carry_out)
);

// File: tb/barrel_rotate_shifter_tb.sv
module barrel_rotate_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] reg_data = '0;
    logic [31:0] imm_data = '0;
    logic        data_sel = 1'b0;
    logic [5:0]  amt_imm = '0;
    logic [5:0]  amt_reg = '0;
    logic        amt_sel = 1'b0;
    logic [1:0]  shift_type = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    barrel_rotate_shifter u_dut (
        .reg_data   (reg_data),
        .imm_data   (imm_data),
        .data_sel   (data_sel),
        .amt_imm    (amt_imm),
        .amt_reg    (amt_reg),
        .amt_sel    (amt_sel),
        .shift_type (shift_type),
        .carry_in   (carry_in),
        .result     (result),
        .carry_out  (carry_out)
    );

    // {data, type, amount, carry_in, expected result, expected carry}
    localparam int NVEC = 16;
    localparam logic [73:0] VECS [NVEC] = '{
        {32'h8000_0001, 2'd0, 6'd1,  1'b0, 32'h0000_0002, 1'b1}, // R3 R5 left
        {32'h8000_0001, 2'd1, 6'd1,  1'b0, 32'h4000_0000, 1'b1}, // R3 R5 right
        {32'h8000_0000, 2'd2, 6'd4,  1'b0, 32'hF800_0000, 1'b0}, // R3 R5 arith
        {32'h0000_000F, 2'd3, 6'd4,  1'b0, 32'hF000_0000, 1'b1}, // R3 R9 rotate
        {32'h1234_5678, 2'd0, 6'd0,  1'b1, 32'h1234_5678, 1'b1}, // R4
        {32'h1234_5678, 2'd3, 6'd0,  1'b0, 32'h1234_5678, 1'b0}, // R4
        {32'h0000_0001, 2'd0, 6'd32, 1'b0, 32'h0000_0000, 1'b1}, // R6 left
        {32'h8000_0000, 2'd1, 6'd32, 1'b0, 32'h0000_0000, 1'b1}, // R6 right
        {32'hFFFF_FFFF, 2'd1, 6'd33, 1'b1, 32'h0000_0000, 1'b0}, // R7
        {32'h7FFF_FFFF, 2'd2, 6'd40, 1'b1, 32'h0000_0000, 1'b0}, // R8 positive
        {32'h8000_0000, 2'd2, 6'd63, 1'b0, 32'hFFFF_FFFF, 1'b1}, // R8 negative
        {32'h8000_0000, 2'd3, 6'd32, 1'b0, 32'h8000_0000, 1'b1}, // R9 mod 32
        {32'h0000_0001, 2'd3, 6'd33, 1'b0, 32'h8000_0000, 1'b1}, // R9 wrap
        {32'h1234_5678, 2'd0, 6'd16, 1'b0, 32'h5678_0000, 1'b0}, // R3 R5
        {32'h1234_5678, 2'd3, 6'd8,  1'b0, 32'h7812_3456, 1'b0}, // R3 R9
        {32'h0001_0000, 2'd1, 6'd16, 1'b0, 32'h0000_0001, 1'b0}  // R3 R5
    };

    function automatic logic [32:0] model(logic [31:0] d, logic [1:0] t, logic [5:0] n, logic ci);
        logic [31:0] r;
        logic        c;
        int          k;
        int          amt;
        amt = int'(n);
        r = d;
        c = ci;
        if (amt != 0) begin
            case (t)
                2'd0: begin
                    if (amt < 32) begin r = d << amt; c = d[32-amt]; end
                    else begin r = '0; c = (amt == 32) ? d[0] : 1'b0; end
                end
                2'd1: begin
                    if (amt < 32) begin r = d >> amt; c = d[amt-1]; end
                    else begin r = '0; c = (amt == 32) ? d[31] : 1'b0; end
                end
                2'd2: begin
                    if (amt < 32) begin r = 32'($signed(d) >>> amt); c = d[amt-1]; end
                    else begin r = {32{d[31]}}; c = d[31]; end
                end
                default: begin
                    k = amt % 32;
                    for (int i = 0; i < 32; i++) r[i] = d[(i + k) % 32];
                    c = r[31];
                end
            endcase
        end
        return {c, r};
    endfunction

    task automatic check(string tag, logic [31:0] exp_r, logic exp_c);
        checks++;
        if (result !== exp_r || carry_out !== exp_c) begin
            failures++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, result, carry_out, exp_r, exp_c);
        end
    endtask

    task automatic drive(logic [31:0] d, logic [1:0] t, logic [5:0] n, logic ci);
        @(negedge clk);
        reg_data   = d;
        imm_data   = ~d;
        data_sel   = 1'b0;
        amt_imm    = n;
        amt_reg    = ~n;
        amt_sel    = 1'b0;
        shift_type = t;
        carry_in   = ci;
        #1;
    endtask

    initial begin
        logic [32:0] e;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // All-zero inputs give a zero word and zero carry (R4)
        #1;
        check("R4 idle", 32'h0, 1'b0);

        for (int v = 0; v < NVEC; v++) begin
            drive(VECS[v][73:42], VECS[v][41:40], VECS[v][39:34], VECS[v][33]);
            check($sformatf("vector %0d (R3-table)", v), VECS[v][32:1], VECS[v][0]);
        end

        // R1: immediate operand replaces the register operand
        @(negedge clk);
        reg_data = 32'hFFFF_0000; imm_data = 32'h0000_00F0; data_sel = 1'b1;
        amt_imm = 6'd4; amt_sel = 1'b0; shift_type = 2'd1; carry_in = 1'b0;
        #1;
        check("R1 immediate operand", 32'h0000_000F, 1'b0);
        @(negedge clk);
        data_sel = 1'b0;
        #1;
        check("R1 register operand", 32'h0FFF_F000, 1'b0);

        // R2: register amount replaces the immediate amount
        @(negedge clk);
        reg_data = 32'h0000_0001; data_sel = 1'b0; shift_type = 2'd0;
        amt_imm = 6'd1; amt_reg = 6'd31; amt_sel = 1'b1; carry_in = 1'b0;
        #1;
        check("R2 register amount", 32'h8000_0000, 1'b0);
        @(negedge clk);
        amt_sel = 1'b0;
        #1;
        check("R2 immediate amount", 32'h0000_0002, 1'b0);

        // Sweep of every type and amount against the bit model (R3 R5 R6 R7 R8 R9)
        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 4; t++) begin
                for (int n = 0; n < 64; n++) begin
                    logic [31:0] d;
                    d = (p == 0) ? 32'hA5C3_0F69 : 32'h4B1E_96D2;
                    drive(d, 2'(t), 6'(n), 1'(n & 1));
                    e = model(d, 2'(t), 6'(n), 1'(n & 1));
                    check($sformatf("R3 sweep type=%0d amt=%0d", t, n), e[31:0], e[32]);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule